// File: doc/BRIEF.md
# Millisecond Elapsed Clock and Interval Timer

This block gives software two clocks that both advance at a one-millisecond rate. A prescaler counts system-clock cycles and emits a one-cycle tick every `TICK_DIV` cycles. The tick drives two counters. The first is a free-running elapsed-time counter that only counts up. It has no write path at all and is meant for timestamps. The second is a down-counting interval timer. Software loads it, and it raises a single-cycle interrupt when it runs out.

Reads go through a registered port that is `BUS_W` bits wide. The elapsed count is wider than that port, so reading its low word captures the whole count in one cycle. A later read of the high word returns the captured upper bits, so software never sees a torn value when a carry happens between the two reads. The interval timer can be reloaded at any time, and a reload overrides a decrement that falls in the same cycle.

Top module: `ms_clock_timer`

## Requirements
- R1: After reset all state is zero: the elapsed count, the interval timer, `rd_data` and `irq`. A tick occurs once every `TICK_DIV` clock cycles, and the elapsed count rises by exactly one per tick. After `n` rising edges since reset release, the count equals floor(n / `TICK_DIV`).
- R2: The elapsed count wraps from all ones to zero. The wrap raises no interrupt and no other indication.
- R3: No input writes the elapsed count. Loads of the interval timer leave it unchanged.
- R4: A cycle with `ld_en` high sets the interval timer to `ld_val` at the next edge. A read with `rd_sel`=2 returns the timer zero-extended to `BUS_W` bits.
- R5: The interval timer falls by one on each tick while it is non-zero and no load is present.
- R6: Once the interval timer reaches zero it stays at zero, without interrupts, until the next load.
- R7: `irq` is high for exactly one cycle, in the cycle after the edge where the timer went from one to zero by a tick. While `irq` is high the timer reads zero.
- R8: A load with value zero sets the timer to zero and raises no interrupt, even when the timer was non-zero before.
- R9: A load that coincides with a tick wins. The timer takes `ld_val` with no decrement. No interrupt is raised even if the timer held one.
- R10: `rd_data` changes only on the edge that samples `rd_en` high, and holds otherwise. The `rd_sel` codes are as follows:
  - 0 returns the low `BUS_W` bits of the elapsed count and captures the rest of the count in the same cycle.
  - 1 returns the upper bits from that capture, zero-extended.
  - 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe, sampled at the rising edge |
| rd_sel | input | 2 | Read word: 0 elapsed low, 1 elapsed high (captured), 2 interval timer, 3 zero |
| rd_data | output | BUS_W | Registered read result |
| ld_en | input | 1 | Interval timer load strobe |
| ld_val | input | TIMER_W | Value for the interval timer |
| irq | output | 1 | One-cycle pulse when the interval timer expires |

## Verification
Two pairs of functions can fall in the same cycle. A timer load can meet a millisecond tick, and a low-word capture of the elapsed count can meet the tick that carries into the high bits. The bench tracks the prescaler phase by counting edges since reset release. It then drives a load exactly on a tick cycle while the timer holds one. The load must win, with no decrement and no interrupt. The same phase tracking lands a low-word read on the edge where a narrow instance steps from 15 to 16. The following high-word read must then return the captured zero and not the live one.

// File: rtl/ms_clk_pkg.sv
package ms_clk_pkg;

    typedef enum logic [1:0] {
        RSEL_CNT_LO = 2'd0,
        RSEL_CNT_HI = 2'd1,
        RSEL_IVT    = 2'd2,
        RSEL_RSVD   = 2'd3
    } rd_sel_e;

    function automatic int width_of(input int max_value);
        return (max_value > 1) ? $clog2(max_value) : 1;
    endfunction

endpackage

// File: rtl/mst_prescaler.sv
module mst_prescaler
    import ms_clk_pkg::*;
#(
    parameter int DIV = 50000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = width_of(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == LAST);

endmodule

// File: rtl/mst_elapsed.sv
module mst_elapsed #(
    parameter int EW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [EW-1:0] count
);
    typedef struct packed {
        logic [EW-1:0] value;
    } el_st_t;

    el_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.value = st_q.value + EW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.value;

endmodule

// File: rtl/mst_interval.sv
module mst_interval #(
    parameter int TW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ld_en,
    input  logic [TW-1:0] ld_val,
    output logic [TW-1:0] count,
    output logic          expire
);
    typedef struct packed {
        logic [TW-1:0] value;
        logic          fire;
    } ivt_st_t;

    ivt_st_t st_d, st_q;
    logic    running;
    logic    last_step;

    always_comb begin
        running   = (st_q.value != '0);
        last_step = (st_q.value == TW'(1));
        st_d      = st_q;
        st_d.fire = 1'b0;
        if (ld_en) begin
            st_d.value = ld_val;
        end else if (tick && running) begin
            st_d.value = st_q.value - TW'(1);
            st_d.fire  = last_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.value;
    assign expire = st_q.fire;

endmodule

// File: rtl/mst_readout.sv
module mst_readout
    import ms_clk_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int EW    = 36,
    parameter int TW    = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [1:0]       rd_sel,
    input  logic [EW-1:0]    elapsed,
    input  logic [TW-1:0]    timer,
    output logic [BUS_W-1:0] rd_data
);
    localparam int HW = (EW > BUS_W) ? (EW - BUS_W) : 1;

    logic [BUS_W-1:0] lo_live;
    logic [HW-1:0]    hi_live;
    rd_sel_e          sel_e;

    generate
        if (EW > BUS_W) begin : g_split
            assign lo_live = elapsed[BUS_W-1:0];
            assign hi_live = elapsed[EW-1:BUS_W];
        end else begin : g_narrow
            assign lo_live = BUS_W'(elapsed);
            assign hi_live = '0;
        end
    endgenerate

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic [HW-1:0]    snap;
    } rd_st_t;

    rd_st_t st_d, st_q;

    assign sel_e = rd_sel_e'(rd_sel);

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            unique case (sel_e)
                RSEL_CNT_LO: begin
                    st_d.data = lo_live;
                    st_d.snap = hi_live;
                end
                RSEL_CNT_HI: st_d.data = BUS_W'(st_q.snap);
                RSEL_IVT:    st_d.data = BUS_W'(timer);
                default:     st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.data;

endmodule

// File: rtl/ms_clock_timer.sv
module ms_clock_timer #(
    parameter int TICK_DIV  = 50000,
    parameter int ELAPSED_W = 36,
    parameter int TIMER_W   = 15,
    parameter int BUS_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [1:0]         rd_sel,
    output logic [BUS_W-1:0]   rd_data,
    input  logic               ld_en,
    input  logic [TIMER_W-1:0] ld_val,
    output logic               irq
);
    logic                 tick;
    logic [ELAPSED_W-1:0] elapsed_cnt;
    logic [TIMER_W-1:0]   timer_cnt;

    mst_prescaler #(
        .DIV (TICK_DIV)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    mst_elapsed #(
        .EW (ELAPSED_W)
    ) u_el (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (elapsed_cnt)
    );

    mst_interval #(
        .TW (TIMER_W)
    ) u_ivt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .ld_en  (ld_en),
        .ld_val (ld_val),
        .count  (timer_cnt),
        .expire (irq)
    );

    mst_readout #(
        .BUS_W (BUS_W),
        .EW    (ELAPSED_W),
        .TW    (TIMER_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .elapsed (elapsed_cnt),
        .timer   (timer_cnt),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/ms_clock_timer_chk.sv
module ms_clock_timer_chk #(
    parameter int EW  = 36,
    parameter int TW  = 15,
    parameter int BW  = 32,
    parameter int DIV = 50000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [EW-1:0] elapsed,
    input logic [TW-1:0] timer,
    input logic          ld_en,
    input logic [TW-1:0] ld_val,
    input logic          irq,
    input logic          rd_en,
    input logic [BW-1:0] rd_data
);
    generate
        if (DIV > 1) begin : g_spacing
            AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R1
        end
    endgenerate

    AST_ELAPSED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (elapsed == ($past(elapsed) + EW'(1)))); // R2

    AST_ELAPSED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(elapsed)); // R3

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (timer == $past(ld_val))); // R9

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && tick && timer != '0) |=> (timer == ($past(timer) - TW'(1)))); // R5

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && timer == '0) |=> (timer == '0 && !irq)); // R6

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (timer == '0)); // R7

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(timer) == TW'(1) && !$past(ld_en) && $past(tick))); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R10

endmodule

bind ms_clock_timer ms_clock_timer_chk #(
    .EW  (ELAPSED_W),
    .TW  (TIMER_W),
    .BW  (BUS_W),
    .DIV (TICK_DIV)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .elapsed (elapsed_cnt),
    .timer   (timer_cnt),
    .ld_en   (ld_en),
    .ld_val  (ld_val),
    .irq     (irq),
    .rd_en   (rd_en),
    .rd_data (rd_data)
);

// File: tb/ms_clock_timer_test.sv
module ms_clock_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;
    localparam int EW  = 36;
    localparam int TW  = 15;
    localparam int BW  = 32;
    localparam int S_DIV = 2;
    localparam int S_EW  = 8;
    localparam int S_TW  = 4;
    localparam int S_BW  = 4;
    localparam logic [1:0] SEL_LO = 2'd0, SEL_HI = 2'd1, SEL_IVT = 2'd2, SEL_RSVD = 2'd3;

    typedef struct packed {
        logic [14:0] ld;
        logic [15:0] wait_cyc;
        logic [7:0]  exp_irq;
        logic        exp_zero;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{15'd3,   16'd20, 8'd1, 1'b1},
        '{15'd0,   16'd12, 8'd0, 1'b1},
        '{15'd1,   16'd8,  8'd1, 1'b1},
        '{15'd2,   16'd40, 8'd1, 1'b1},
        '{15'd200, 16'd10, 8'd0, 1'b0},
        '{15'd0,   16'd6,  8'd0, 1'b1},
        '{15'd5,   16'd30, 8'd1, 1'b1},
        '{15'd0,   16'd6,  8'd0, 1'b1},
        '{15'd7,   16'd40, 8'd1, 1'b1}
    };

    logic          clk;
    logic          rst_n;
    logic          rd_en;
    logic [1:0]    rd_sel;
    logic [BW-1:0] rd_data;
    logic          ld_en;
    logic [TW-1:0] ld_val;
    logic          irq;

    logic            s_rd_en;
    logic [1:0]      s_rd_sel;
    logic [S_BW-1:0] s_rd_data;
    logic            s_ld_en;
    logic [S_TW-1:0] s_ld_val;
    logic            s_irq;

    int checks;
    int errors;
    int edge_cnt;
    int irq_seen;
    int cnt_m;
    logic [TW-1:0] tm_m;
    logic          irq_m;
    logic          tick_m;

    ms_clock_timer #(
        .TICK_DIV(DIV), .ELAPSED_W(EW), .TIMER_W(TW), .BUS_W(BW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .ld_en(ld_en), .ld_val(ld_val), .irq(irq)
    );

    ms_clock_timer #(
        .TICK_DIV(S_DIV), .ELAPSED_W(S_EW), .TIMER_W(S_TW), .BUS_W(S_BW)
    ) uut_small (
        .clk(clk), .rst_n(rst_n), .rd_en(s_rd_en), .rd_sel(s_rd_sel), .rd_data(s_rd_data),
        .ld_en(s_ld_en), .ld_val(s_ld_val), .irq(s_irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    assign tick_m = (cnt_m == DIV - 1);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_cnt <= 0;
            cnt_m    <= 0;
            tm_m     <= '0;
            irq_m    <= 1'b0;
        end else begin
            edge_cnt <= edge_cnt + 1;
            cnt_m    <= tick_m ? 0 : cnt_m + 1;
            if (ld_en) tm_m <= ld_val;
            else if (tick_m && tm_m != '0) tm_m <= tm_m - 1'b1;
            irq_m <= !ld_en && tick_m && (tm_m == 15'd1);
        end
    end

    // irq pulse monitor (R7) and small-instance silence on wrap (R2)
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irq_seen = irq_seen + 1;
            if (irq !== irq_m) begin
                checks = checks + 1;
                errors = errors + 1;
                $display("FAIL R7 irq monitor at edge %0d: got %b expected %b", edge_cnt, irq, irq_m);
            end
            if (s_irq !== 1'b0) begin
                checks = checks + 1;
                errors = errors + 1;
                $display("FAIL R2 narrow instance irq: got %b expected 0", s_irq);
            end
        end
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd_main(input logic [1:0] sel, output logic [63:0] val,
                           output int e_at, output logic [TW-1:0] t_at);
        e_at   = edge_cnt;
        t_at   = tm_m;
        rd_en  = 1'b1;
        rd_sel = sel;
        @(negedge clk);
        rd_en  = 1'b0;
        val    = 64'(rd_data);
    endtask

    task automatic load_main(input logic [TW-1:0] v);
        ld_en  = 1'b1;
        ld_val = v;
        @(negedge clk);
        ld_en  = 1'b0;
    endtask

    task automatic wait_tick();
        while (!tick_m) @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL R1 watchdog: got running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0]   val;
        logic [63:0]   lo_v;
        logic [63:0]   hi_v;
        int            e_at;
        logic [TW-1:0] t_at;
        int            irq_before;
        checks   = 0;
        errors   = 0;
        irq_seen = 0;
        rst_n    = 1'b0;
        rd_en    = 1'b0;
        rd_sel   = 2'd0;
        ld_en    = 1'b0;
        ld_val   = '0;
        s_rd_en  = 1'b0;
        s_rd_sel = 2'd0;
        s_ld_en  = 1'b0;
        s_ld_val = '0;
        idle(3);
        check("R1 reset rd_data", 64'(rd_data), 64'd0);
        check("R1 reset irq", 64'(irq), 64'd0);
        rst_n = 1'b1;

        rd_main(SEL_LO, val, e_at, t_at);
        check("R1 elapsed right after reset", val, 64'(e_at / DIV));
        rd_main(SEL_IVT, val, e_at, t_at);
        check("R1 timer zero after reset", val, 64'd0);
        idle(9);
        rd_main(SEL_LO, val, e_at, t_at);
        check("R1 elapsed after 10 edges", val, 64'(e_at / DIV));

        // table walk: load, wait, read timer, count pulses (R4 R5 R6 R7 R8)
        for (int k = 0; k < NVEC; k++) begin
            irq_before = irq_seen;
            load_main(VECS[k].ld);
            idle(int'(VECS[k].wait_cyc));
            rd_main(SEL_IVT, val, e_at, t_at);
            if (VECS[k].exp_zero) check("R6 timer parked at zero", val, 64'd0);
            else                  check("R5 timer counting down", val, 64'(t_at));
            check("R7 R8 pulse count for vector", 64'(irq_seen - irq_before), 64'(VECS[k].exp_irq));
        end

        rd_main(SEL_LO, val, e_at, t_at);
        check("R3 elapsed untouched by loads", val, 64'(e_at / DIV));
        rd_main(SEL_HI, val, e_at, t_at);
        check("R10 captured high word", val, 64'd0);

        // load colliding with tick (R9)
        irq_before = irq_seen;
        wait_tick();
        load_main(15'd1);
        rd_main(SEL_IVT, val, e_at, t_at);
        check("R9 load of 1 on tick cycle", val, 64'd1);
        wait_tick();
        load_main(15'd9);
        rd_main(SEL_IVT, val, e_at, t_at);
        check("R9 reload over expiring tick", val, 64'd9);
        check("R9 no pulse on overridden expiry", 64'(irq_seen - irq_before), 64'd0);

        // full-width load (R4)
        load_main(15'h7FFF);
        rd_main(SEL_IVT, val, e_at, t_at);
        check("R4 full width load read back", val, 64'h7FFF);

        // reserved select and hold (R10)
        rd_main(SEL_RSVD, val, e_at, t_at);
        check("R10 reserved select reads zero", val, 64'd0);
        idle(7);
        check("R10 rd_data holds without strobe", 64'(rd_data), 64'd0);

        // narrow instance: carry between words (R10) and wrap (R2)
        while ((edge_cnt % 512) != 31) @(negedge clk);
        s_rd_en  = 1'b1;
        s_rd_sel = SEL_LO;
        @(negedge clk);
        lo_v     = 64'(s_rd_data);
        s_rd_sel = SEL_HI;
        @(negedge clk);
        s_rd_en  = 1'b0;
        hi_v     = 64'(s_rd_data);
        check("R10 low word at carry edge", lo_v, 64'hF);
        check("R10 high word from capture not live", hi_v, 64'd0);

        while (!(edge_cnt >= 512 && (edge_cnt % 512) == 4)) @(negedge clk);
        s_rd_en  = 1'b1;
        s_rd_sel = SEL_LO;
        @(negedge clk);
        lo_v     = 64'(s_rd_data);
        s_rd_sel = SEL_HI;
        @(negedge clk);
        s_rd_en  = 1'b0;
        hi_v     = 64'(s_rd_data);
        check("R2 low word after wrap", lo_v, 64'd2);
        check("R2 high word after wrap", hi_v, 64'd0);

        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule